// File: doc/BRIEF.md
# Flash Command Decoder with Status and Block Locks

This block sits behind the write strobe of a parallel flash host bus. It turns single-write and two-write command sequences into a read-source selection and into jobs for an embedded operation engine. The job types are block erase, word program, lock set, clear all locks and one-time-area program. It holds the 16-bit status word, a lock bit for each block, and the bookkeeping for suspend and resume. An erase can be suspended, a program can run inside that suspension, and the program can be suspended as well.

The read path returns the status word or the identifier and lock data. For array and query reads it only reports which source is selected, because array storage and the query table sit outside the block. The engine is external. It receives a one-cycle launch pulse with the latched address and data. It advances only while the run output is high, and it answers with a done pulse and a fail flag.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the read source is array (rd_sel = 0), no job runs (eng_run = 0), the status reads 0x0080 and every lock bit is clear.
- R2: A write of FFh, 90h, 98h or 70h selects read source array (0), identifier (1), query (2) or status (3). Any other code in the first write leaves the read source unchanged.
- R3: With the identifier source, address 0 reads 0x00B0, address 1 reads 0x0017, and offset 2 of any block reads that block's lock bit on bit 0. Every other address reads zero.
- R4: The status word has these bits: 7 ready, 6 erase suspended, 5 erase or clear-locks error, 4 program, one-time or lock-set error, 3 low program voltage, 2 program suspended, 1 locked-block attempt. Bits 15:8 and 0 read zero, and the whole word reads 0x0000 while a job runs.
- R5: 20h then D0h launches an erase. 40h or 10h followed by an address/data write launches a program. The launch is a one-cycle job_go after the second write, carrying that write's address and data, and the read source becomes status.
- R6: 60h then 01h sets the lock bit of the addressed block once the engine reports success. 60h then D0h clears the lock bits of all blocks.
- R7: An erase or program aimed at a locked block is not launched. It sets bit 1 together with bit 5 (erase) or bit 4 (program).
- R8: If the program-voltage flag is low at the second write, no job is launched, and bit 3 is set together with that job's class error bit. This check takes precedence over the lock check.
- R9: In an erase or lock sequence, a second write with an unexpected code launches nothing and sets both bits 5 and 4.
- R10: Error bits stay set until a 50h write clears them, and new jobs are still accepted while they are set. An engine fail sets bit 5 for erase and clear-locks, and bit 4 for the other job types.
- R11: B0h pauses a running erase or program: eng_run drops, and bit 6 or bit 2 is set. A program may be launched while an erase is suspended.
- R12: D0h resumes the suspended program first. Only when no program is pending does it resume a suspended erase.
- R13: While a job runs, every write other than B0h and 70h is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host command write strobe, one cycle per write |
| addr | input | ADDR_W | Word address, block number in the upper BLK_W bits |
| wdata | input | 16 | Write data; command code in bits 7:0 |
| vpen_ok | input | 1 | Program voltage is within range |
| eng_done | input | 1 | Engine finished the running job |
| eng_fail | input | 1 | Qualifies eng_done: the job failed |
| rd_sel | output | 2 | Read source: 0 array, 1 identifier, 2 query, 3 status |
| rd_data | output | 16 | Read data for the status and identifier sources |
| eng_run | output | 1 | Engine may advance the current job |
| run_kind | output | 3 | Current job: 0 none, 1 erase, 2 program, 3 lock set, 4 clear locks, 5 one-time program |
| job_go | output | 1 | One-cycle launch pulse |
| job_addr | output | ADDR_W | Address latched at launch |
| job_data | output | 16 | Data latched at launch |

## Verification
The bench builds the block with 8 blocks of 16 words, so addresses are 7 bits wide. With that size, random addresses hit every block base and every lock-bit offset often, and random lock and clear-all sequences can cover the whole lock array. Its engine model keeps separate cycle counters for erase and program, with a job length of 12 cycles. This leaves room to suspend an erase, run and suspend a program inside it, and then check the order in which resume brings them back.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [1:0] {
        RD_ARRAY  = 2'd0,
        RD_IDENT  = 2'd1,
        RD_QUERY  = 2'd2,
        RD_STATUS = 2'd3
    } rd_src_e;

    typedef enum logic [2:0] {
        JOB_NONE     = 3'd0,
        JOB_ERASE    = 3'd1,
        JOB_PROG     = 3'd2,
        JOB_LOCK_SET = 3'd3,
        JOB_LOCK_CLR = 3'd4,
        JOB_OTP      = 3'd5
    } job_e;

    typedef enum logic [2:0] {
        SEQ_IDLE, SEQ_ERASE, SEQ_PROG, SEQ_LOCK, SEQ_OTP
    } seq_e;

    typedef struct packed {
        logic ers;   // erase / clear-locks failure
        logic pgm;   // program / one-time / lock-set failure
        logic vpp;   // program voltage low
        logic lck;   // locked block hit
    } err_t;

    localparam logic [7:0] C_READ_ARRAY = 8'hFF;
    localparam logic [7:0] C_READ_IDENT = 8'h90;
    localparam logic [7:0] C_READ_QUERY = 8'h98;
    localparam logic [7:0] C_READ_STAT  = 8'h70;
    localparam logic [7:0] C_CLR_STAT   = 8'h50;
    localparam logic [7:0] C_ERASE      = 8'h20;
    localparam logic [7:0] C_PROG_A     = 8'h40;
    localparam logic [7:0] C_PROG_B     = 8'h10;
    localparam logic [7:0] C_LOCK       = 8'h60;
    localparam logic [7:0] C_LOCK_SET   = 8'h01;
    localparam logic [7:0] C_OTP        = 8'hC0;
    localparam logic [7:0] C_SUSPEND    = 8'hB0;
    localparam logic [7:0] C_CONFIRM    = 8'hD0;

    localparam logic [15:0] ID_MAKER  = 16'h00B0;
    localparam logic [15:0] ID_DEVICE = 16'h0017;

    function automatic logic [15:0] pack_status(input logic ready, input logic e_sus,
                                                input logic p_sus, input err_t e);
        return ready ? {8'h00, 1'b1, e_sus, e.ers, e.pgm, e.vpp, p_sus, e.lck, 1'b0}
                     : 16'h0000;
    endfunction

endpackage

// File: rtl/flash_lock_bank.sv
module flash_lock_bank #(
    parameter int NUM_BLK = 64,
    localparam int BLK_W = $clog2(NUM_BLK)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic [BLK_W-1:0] set_blk,
    input  logic             clr_all,
    input  logic [BLK_W-1:0] q_blk,
    output logic             q_hit
);
    logic [NUM_BLK-1:0] bits;

    generate
        for (genvar g = 0; g < NUM_BLK; g++) begin : g_blk
            logic b;
            always_ff @(posedge clk) begin
                if (rst || clr_all)
                    b <= 1'b0;
                else if (set_en && set_blk == BLK_W'(g))
                    b <= 1'b1;
            end
            assign bits[g] = b;
        end
    endgenerate

    assign q_hit = bits[q_blk];
endmodule

// File: rtl/flash_rd_mux.sv
module flash_rd_mux
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int OFF_W  = 16
) (
    input  rd_src_e           src,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       status,
    input  logic              lock_hit,
    output logic [15:0]       rd_data
);
    always_comb begin
        rd_data = 16'h0000;
        case (src)
            RD_STATUS: rd_data = status;
            RD_IDENT: begin
                if (addr == ADDR_W'(0))
                    rd_data = ID_MAKER;
                else if (addr == ADDR_W'(1))
                    rd_data = ID_DEVICE;
                else if (addr[OFF_W-1:0] == OFF_W'(2))
                    rd_data = {15'h0, lock_hit};
            end
            default: rd_data = 16'h0000;
        endcase
    end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int OFF_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    input  logic              vpen_ok,
    input  logic              eng_done,
    input  logic              eng_fail,
    input  logic              lock_hit,
    output rd_src_e           rd_src,
    output logic [15:0]       status,
    output logic              eng_run,
    output job_e              run_kind,
    output logic              job_go,
    output logic [ADDR_W-1:0] job_addr,
    output logic [15:0]       job_data,
    output logic              lk_set,
    output logic              lk_clr
);
    seq_e       seq;
    err_t       err;
    logic       e_act, e_sus, p_sus, p_busy;
    job_e       p_kind;
    logic [7:0] cmd;

    assign cmd      = wdata[7:0];
    assign p_busy   = (p_kind != JOB_NONE);
    assign eng_run  = (p_busy && !p_sus) || (e_act && !e_sus && !p_busy);
    assign run_kind = p_busy ? p_kind : (e_act ? JOB_ERASE : JOB_NONE);
    assign status   = pack_status(!eng_run, e_sus, p_sus, err);

    always_ff @(posedge clk) begin
        if (rst) begin
            seq      <= SEQ_IDLE;
            rd_src   <= RD_ARRAY;
            err      <= '0;
            e_act    <= 1'b0;
            e_sus    <= 1'b0;
            p_sus    <= 1'b0;
            p_kind   <= JOB_NONE;
            job_go   <= 1'b0;
            job_addr <= '0;
            job_data <= '0;
            lk_set   <= 1'b0;
            lk_clr   <= 1'b0;
        end else begin
            job_go <= 1'b0;
            lk_set <= 1'b0;
            lk_clr <= 1'b0;
            // completion of the running job
            if (eng_done && eng_run) begin
                if (p_busy) begin
                    if (p_kind == JOB_LOCK_CLR) begin
                        if (eng_fail) err.ers <= 1'b1;
                        else          lk_clr  <= 1'b1;
                    end else begin
                        if (eng_fail) err.pgm <= 1'b1;
                        else if (p_kind == JOB_LOCK_SET) lk_set <= 1'b1;
                    end
                    p_kind <= JOB_NONE;
                end else begin
                    if (eng_fail) err.ers <= 1'b1;
                    e_act <= 1'b0;
                end
            end
            // host writes
            if (wr_en) begin
                if (eng_run) begin
                    if (cmd == C_SUSPEND && !eng_done) begin
                        if (p_kind == JOB_PROG) p_sus <= 1'b1;
                        else if (!p_busy)       e_sus <= 1'b1;
                    end else if (cmd == C_READ_STAT) begin
                        rd_src <= RD_STATUS;
                    end
                end else if (seq != SEQ_IDLE) begin
                    seq    <= SEQ_IDLE;
                    rd_src <= RD_STATUS;
                    case (seq)
                        SEQ_ERASE: begin
                            if (cmd != C_CONFIRM) begin
                                err.ers <= 1'b1; err.pgm <= 1'b1;
                            end else if (!vpen_ok) begin
                                err.vpp <= 1'b1; err.ers <= 1'b1;
                            end else if (lock_hit) begin
                                err.lck <= 1'b1; err.ers <= 1'b1;
                            end else begin
                                e_act <= 1'b1; e_sus <= 1'b0; job_go <= 1'b1;
                                job_addr <= addr; job_data <= wdata;
                            end
                        end
                        SEQ_PROG: begin
                            if (!vpen_ok) begin
                                err.vpp <= 1'b1; err.pgm <= 1'b1;
                            end else if (lock_hit) begin
                                err.lck <= 1'b1; err.pgm <= 1'b1;
                            end else begin
                                p_kind <= JOB_PROG; p_sus <= 1'b0; job_go <= 1'b1;
                                job_addr <= addr; job_data <= wdata;
                            end
                        end
                        SEQ_LOCK: begin
                            if (cmd == C_LOCK_SET) begin
                                if (!vpen_ok) begin
                                    err.vpp <= 1'b1; err.pgm <= 1'b1;
                                end else begin
                                    p_kind <= JOB_LOCK_SET; job_go <= 1'b1;
                                    job_addr <= addr; job_data <= wdata;
                                end
                            end else if (cmd == C_CONFIRM) begin
                                if (!vpen_ok) begin
                                    err.vpp <= 1'b1; err.ers <= 1'b1;
                                end else begin
                                    p_kind <= JOB_LOCK_CLR; job_go <= 1'b1;
                                    job_addr <= addr; job_data <= wdata;
                                end
                            end else begin
                                err.ers <= 1'b1; err.pgm <= 1'b1;
                            end
                        end
                        default: begin
                            if (!vpen_ok) begin
                                err.vpp <= 1'b1; err.pgm <= 1'b1;
                            end else begin
                                p_kind <= JOB_OTP; job_go <= 1'b1;
                                job_addr <= addr; job_data <= wdata;
                            end
                        end
                    endcase
                end else begin
                    case (cmd)
                        C_READ_ARRAY: rd_src <= RD_ARRAY;
                        C_READ_IDENT: rd_src <= RD_IDENT;
                        C_READ_QUERY: rd_src <= RD_QUERY;
                        C_READ_STAT:  rd_src <= RD_STATUS;
                        C_CLR_STAT:   err    <= '0;
                        C_ERASE:      if (!e_act && !p_busy) seq <= SEQ_ERASE;
                        C_PROG_A,
                        C_PROG_B:     if (!p_busy) seq <= SEQ_PROG;
                        C_LOCK:       if (!e_act && !p_busy) seq <= SEQ_LOCK;
                        C_OTP:        if (!e_act && !p_busy) seq <= SEQ_OTP;
                        C_CONFIRM: begin
                            if (p_sus)                e_sus <= e_sus;
                            if (p_sus)                p_sus <= 1'b0;
                            else if (e_sus && !p_busy) e_sus <= 1'b0;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int NUM_BLK   = 64,
    parameter int BLK_WORDS = 65536,
    localparam int BLK_W  = $clog2(NUM_BLK),
    localparam int OFF_W  = $clog2(BLK_WORDS),
    localparam int ADDR_W = BLK_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    input  logic              vpen_ok,
    input  logic              eng_done,
    input  logic              eng_fail,
    output logic [1:0]        rd_sel,
    output logic [15:0]       rd_data,
    output logic              eng_run,
    output logic [2:0]        run_kind,
    output logic              job_go,
    output logic [ADDR_W-1:0] job_addr,
    output logic [15:0]       job_data
);
    rd_src_e     src;
    job_e        kind;
    logic [15:0] status;
    logic        lock_hit, lk_set, lk_clr;

    flash_cmd_seq #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_seq (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .vpen_ok(vpen_ok), .eng_done(eng_done), .eng_fail(eng_fail),
        .lock_hit(lock_hit), .rd_src(src), .status(status), .eng_run(eng_run),
        .run_kind(kind), .job_go(job_go), .job_addr(job_addr), .job_data(job_data),
        .lk_set(lk_set), .lk_clr(lk_clr)
    );

    flash_lock_bank #(.NUM_BLK(NUM_BLK)) u_locks (
        .clk(clk), .rst(rst), .set_en(lk_set), .set_blk(job_addr[ADDR_W-1:OFF_W]),
        .clr_all(lk_clr), .q_blk(addr[ADDR_W-1:OFF_W]), .q_hit(lock_hit)
    );

    flash_rd_mux #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_mux (
        .src(src), .addr(addr), .status(status), .lock_hit(lock_hit), .rd_data(rd_data)
    );

    assign rd_sel   = src;
    assign run_kind = kind;
endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk (
    input logic        clk,
    input logic        rst,
    input logic        vpen_ok,
    input logic        eng_done,
    input logic [1:0]  rd_sel,
    input logic [15:0] rd_data,
    input logic        eng_run,
    input logic        job_go
);
    AST_RESET_ARRAY: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> rd_sel == 2'd0);                                    // R1
    AST_BUSY_STATUS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (eng_run && rd_sel == 2'd3) |-> rd_data == 16'h0000);               // R4
    AST_IDLE_STATUS_SHAPE: assert property (@(posedge clk) disable iff (rst)
        (!eng_run && rd_sel == 2'd3) |-> (rd_data[7] && !rd_data[0] && rd_data[15:8] == 8'h00)); // R4
    AST_GO_SHOWS_STATUS: assert property (@(posedge clk) disable iff (rst)
        job_go |-> (rd_sel == 2'd3 && eng_run));                            // R5
    AST_GO_SINGLE: assert property (@(posedge clk) disable iff (rst)
        job_go |=> !job_go);                                                // R5
    AST_GO_NEEDS_VPEN: assert property (@(posedge clk) disable iff (rst)
        job_go |-> $past(vpen_ok));                                         // R8
    AST_DONE_STOPS_RUN: assert property (@(posedge clk) disable iff (rst)
        (eng_done && eng_run) |=> !eng_run);                                // R10
endmodule

bind flash_cmd_ctrl flash_cmd_chk u_chk (
    .clk(clk), .rst(rst), .vpen_ok(vpen_ok), .eng_done(eng_done),
    .rd_sel(rd_sel), .rd_data(rd_data), .eng_run(eng_run), .job_go(job_go)
);

// File: tb/test_flash_cmd_ctrl.sv
module test_flash_cmd_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 8;
    localparam int BW = 16;
    localparam int OFF_W = 4;
    localparam int AW = 7;
    localparam int ENG_CYC = 12;

    logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [15:0] wdata = '0;
    logic vpen_ok = 1'b1, eng_done = 1'b0, eng_fail = 1'b0, fail_next = 1'b0;
    logic [1:0] rd_sel;
    logic [15:0] rd_data;
    logic eng_run, job_go;
    logic [2:0] run_kind;
    logic [AW-1:0] job_addr;
    logic [15:0] job_data;
    logic [NB-1:0] m_lock = '0;
    int n_chk = 0, n_bad = 0, cnt_e = 0, cnt_p = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_ctrl #(.NUM_BLK(NB), .BLK_WORDS(BW)) i_flash_cmd_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .vpen_ok(vpen_ok), .eng_done(eng_done), .eng_fail(eng_fail),
        .rd_sel(rd_sel), .rd_data(rd_data), .eng_run(eng_run), .run_kind(run_kind),
        .job_go(job_go), .job_addr(job_addr), .job_data(job_data)
    );

    // engine stub: separate counters for erase and other jobs
    always @(negedge clk) begin
        if (rst) begin
            cnt_e = 0; cnt_p = 0; eng_done = 0; eng_fail = 0;
        end else begin
            eng_done = 0; eng_fail = 0;
            if (eng_run) begin
                if (run_kind == 3'd1) begin
                    cnt_e++;
                    if (cnt_e >= ENG_CYC) begin cnt_e = 0; eng_done = 1; eng_fail = fail_next; end
                end else begin
                    cnt_p++;
                    if (cnt_p >= ENG_CYC) begin cnt_p = 0; eng_done = 1; eng_fail = fail_next; end
                end
            end
        end
    end

    function automatic logic [AW-1:0] ba(input int b, input int o);
        return {3'(b), 4'(o)};
    endfunction

    function automatic logic [15:0] exp_ident(input logic [AW-1:0] a, input logic [NB-1:0] lk);
        if (a == 0) return 16'h00B0;
        if (a == 1) return 16'h0017;
        if (a[OFF_W-1:0] == 4'd2) return {15'h0, lk[a[AW-1:OFF_W]]};
        return 16'h0000;
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
        @(negedge clk); wr_en = 1; addr = a; wdata = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic peek(input logic [AW-1:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk); addr = a; #1;
        chk(tag, rd_data, exp);
    endtask

    task automatic wait_idle;
        int t = 0;
        while (eng_run && t < 2000) begin @(negedge clk); t++; end
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 rd_sel", 16'(rd_sel), 16'd0);
        chk("R1 eng_run", 16'(eng_run), 16'd0);
        wr(0, 16'h0070);
        peek(0, 16'h0080, "R1 status");
        wr(0, 16'h0090);
        chk("R2 ident sel", 16'(rd_sel), 16'd1);
        peek(0, 16'h00B0, "R3 maker");
        peek(1, 16'h0017, "R3 device");
        peek(ba(3,2), 16'h0000, "R1 lock clear");
        peek(ba(3,5), 16'h0000, "R3 other addr");
        wr(0, 16'h0098);
        chk("R2 query sel", 16'(rd_sel), 16'd2);
        wr(0, 16'h0033);
        chk("R2 unlisted keeps", 16'(rd_sel), 16'd2);
        wr(0, 16'h00FF);
        chk("R2 array sel", 16'(rd_sel), 16'd0);

        // R6 lock set on block 3
        wr(0, 16'h0060); wr(ba(3,0), 16'h0001);
        chk("R6 go", 16'(job_go), 16'd1);
        chk("R5 status sel", 16'(rd_sel), 16'd3);
        peek(0, 16'h0000, "R4 busy reads zero");
        wr(0, 16'h00FF);
        chk("R13 ignored while busy", 16'(rd_sel), 16'd3);
        wait_idle();
        m_lock[3] = 1;
        wr(0, 16'h0090);
        peek(ba(3,2), 16'h0001, "R6 lock set");
        peek(ba(2,2), 16'h0000, "R6 other block");

        // R7 erase locked block
        wr(ba(3,0), 16'h0020); wr(ba(3,0), 16'h00D0);
        chk("R7 no go", 16'(job_go), 16'd0);
        peek(0, 16'h00A2, "R7 erase locked");
        // R10 sticky, still accepts
        wr(ba(2,0), 16'h0020); wr(ba(2,0), 16'h00D0);
        chk("R10 accepted with errors", 16'(job_go), 16'd1);
        chk("R5 erase kind", 16'(run_kind), 16'd1);
        wait_idle();
        peek(0, 16'h00A2, "R10 sticky");
        wr(0, 16'h0050);
        peek(0, 16'h0080, "R10 cleared");
        // program to locked block
        wr(0, 16'h0040); wr(ba(3,5), 16'h55AA);
        peek(0, 16'h0092, "R7 program locked");
        wr(0, 16'h0050);
        // R8 voltage low, precedence over lock
        vpen_ok = 0;
        wr(0, 16'h0040); wr(ba(3,5), 16'h1234);
        chk("R8 no go", 16'(job_go), 16'd0);
        peek(0, 16'h0098, "R8 vpen program");
        wr(0, 16'h0050);
        wr(ba(1,0), 16'h0020); wr(ba(1,0), 16'h00D0);
        peek(0, 16'h00A8, "R8 vpen erase");
        vpen_ok = 1;
        wr(0, 16'h0050);
        // R9 improper sequences
        wr(ba(2,0), 16'h0020); wr(ba(2,0), 16'h0033);
        peek(0, 16'h00B0, "R9 erase improper");
        wr(0, 16'h0050);
        wr(0, 16'h0060); wr(0, 16'h0077);
        peek(0, 16'h00B0, "R9 lock improper");
        wr(0, 16'h0050);
        // R5 program with alternate code
        wr(0, 16'h0010); wr(ba(2,5), 16'hA5C3);
        chk("R5 go", 16'(job_go), 16'd1);
        chk("R5 job_addr", 16'(job_addr), 16'(ba(2,5)));
        chk("R5 job_data", job_data, 16'hA5C3);
        chk("R5 prog kind", 16'(run_kind), 16'd2);
        wait_idle();
        peek(0, 16'h0080, "R5 done");
        // R10 engine fail
        fail_next = 1;
        wr(0, 16'h0040); wr(ba(4,1), 16'h0001);
        wait_idle();
        fail_next = 0;
        peek(0, 16'h0090, "R10 program fail");
        wr(0, 16'h0050);

        // R11 / R12 nested suspend
        wr(ba(1,0), 16'h0020); wr(ba(1,0), 16'h00D0);
        repeat (3) @(negedge clk);
        wr(0, 16'h00B0);
        chk("R11 erase paused", 16'(eng_run), 16'd0);
        peek(0, 16'h00C0, "R11 erase susp");
        wr(0, 16'h0040); wr(ba(5,3), 16'h0F0F);
        chk("R11 prog in suspend", 16'(run_kind), 16'd2);
        chk("R11 prog runs", 16'(eng_run), 16'd1);
        wr(0, 16'h00B0);
        chk("R11 prog paused", 16'(eng_run), 16'd0);
        peek(0, 16'h00C4, "R11 both susp");
        wr(0, 16'h00D0);
        chk("R12 prog first", 16'(run_kind), 16'd2);
        chk("R12 prog running", 16'(eng_run), 16'd1);
        wait_idle();
        peek(0, 16'h00C0, "R12 erase still susp");
        wr(0, 16'h00D0);
        chk("R12 erase resumed", 16'(run_kind), 16'd1);
        chk("R12 erase running", 16'(eng_run), 16'd1);
        wait_idle();
        peek(0, 16'h0080, "R12 all done");

        // R6 clear all
        wr(0, 16'h0060); wr(0, 16'h00D0);
        chk("R6 clear go", 16'(job_go), 16'd1);
        wait_idle();
        m_lock = '0;
        wr(0, 16'h0090);
        peek(ba(3,2), 16'h0000, "R6 cleared");

        // random phase
        begin
            logic [1:0] mode = 2'd1;
            for (int i = 0; i < 300; i++) begin
                int r = $urandom % 8;
                int b = $urandom % NB;
                logic [AW-1:0] ra = AW'($urandom);
                logic [7:0] c;
                case (r)
                    0: begin wr(ra, 16'h00FF); mode = 0; end
                    1: begin wr(ra, 16'h0090); mode = 1; end
                    2: begin wr(ra, 16'h0098); mode = 2; end
                    3: begin wr(ra, 16'h0070); mode = 3; end
                    4: begin
                        c = 8'($urandom);
                        if (c inside {8'hFF,8'h90,8'h98,8'h70,8'h50,8'h20,8'h40,8'h10,
                                      8'h60,8'hC0,8'hB0,8'hD0}) c = 8'h33;
                        wr(ra, {8'($urandom), c});
                    end
                    5: begin
                        wr(0, 16'h0060); wr(ba(b,0), 16'h0001);
                        wait_idle(); m_lock[b] = 1; mode = 3;
                    end
                    6: begin
                        if ($urandom % 4 == 0) begin
                            wr(0, 16'h0060); wr(0, 16'h00D0);
                            wait_idle(); m_lock = '0; mode = 3;
                        end
                    end
                    default: begin
                        if (mode == 1) peek(ra, exp_ident(ra, m_lock), "R3 random ident");
                        else if (mode == 3) peek(ra, 16'h0080, "R4 random status");
                    end
                endcase
                chk("R2 random mode", 16'(rd_sel), 16'(mode));
                if (mode == 1) begin
                    logic [AW-1:0] la = ba(b, 2);
                    peek(la, exp_ident(la, m_lock), "R6 random lock");
                end
            end
        end
        finish_run();
    end
endmodule